// File: doc/BRIEF.md
# Narrow Strobe Capture Synchronizer

This block takes a strobe from outside the system clock domain, however short its high time, and turns each rising edge into exactly one pulse that lasts one system clock cycle. The strobe never has to be oversampled. Its rising edge clocks a small front flop directly. A short flop chain then carries the result into the clock domain, and an edge detector shapes the output pulse.

The parameter `MODE` selects one of two front ends. In latch mode, a flop with its data input held at one is set by the strobe edge. The clock domain clears this flop asynchronously once it has seen the flop's level. In toggle mode, a flop flips its state on every strobe edge and has no clear path from the clock domain. A change in the synchronized level marks an event.

The parameter `FAST_CLK` adds one register of latency. In toggle mode this extra register lets the comparison use later stages. In latch mode the pulse comes from a self-clearing third flop rather than from a gate. Either way, the second synchronizer stage gets a full cycle to settle. Typical use is the address-latch or access strobe of an asynchronous memory-style bus.

Top module: `strobe_pulse_sync`

## Requirements
- R1: In latch mode, a rising edge on `strobe_i` sets the front flop whatever the strobe width, and the event is never lost while reset is low. A strobe only 0.05 ns wide still yields a pulse.
- R2: In latch mode, the front flop is cleared asynchronously while the second synchronizer stage is high. Whenever that stage is high at a clock edge, the front flop reads low.
- R3: Each isolated strobe produces exactly one `pulse_o`, and that pulse is high for exactly one clock cycle.
- R4: A strobe edge that falls between clock edge E0 and clock edge E1 makes `pulse_o` high in the cycle after edge E2 when `FAST_CLK`=0, and in the cycle after edge E3 when `FAST_CLK`=1.
- R5: In toggle mode (`MODE`=CAP_TOGGLE, encoding 1), the front flop inverts on every strobe edge. The first synchronizer stage changes only toward a front level that differs from it.
- R6: With `FAST_CLK`=1, the latency is one cycle longer and the pulse stays one cycle wide in both modes.
- R7: Two strobe edges inside the same clock period give one pulse in latch mode (`MODE`=CAP_LATCH, encoding 0) and no pulse in toggle mode.
- R8: While `rst_i` is high, all flops are cleared, strobes are ignored and `pulse_o` is low. No pulse appears in the first cycle after release, and an event in flight when reset is applied produces no pulse.
- R9: Strobes whose rising edges are at least 5 clock periods apart each produce their own pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Active-high asynchronous reset for all flops |
| strobe_i | input | 1 | Asynchronous strobe; only the rising edge matters |
| pulse_o | output | 1 | One-cycle pulse per captured strobe event |

## Verification
The bench builds four instances side by side on one strobe: latch and toggle mode, each with `FAST_CLK` at 0 and at 1. This covers both front ends and both pulse-shaping variants, including the self-clearing third flop. A single stimulus stream therefore exposes the differences between the modes. The clearest case is a double strobe inside one clock period, which must give one pulse in latch mode and none in toggle mode. The same stream also shows the one-cycle latency step that `FAST_CLK` adds.

// File: rtl/nsc_pkg.sv
`timescale 1ns/1ps
package nsc_pkg;

  typedef enum logic {
    CAP_LATCH  = 1'b0,
    CAP_TOGGLE = 1'b1
  } cap_mode_e;

  // number of synchronizer flops ahead of the pulse-shaping register
  function automatic int unsigned sync_depth(cap_mode_e mode, bit fast);
    return (mode == CAP_TOGGLE && fast) ? 3 : 2;
  endfunction

  // clock edges after the one preceding the strobe until pulse_o is high
  function automatic int unsigned pulse_latency(bit fast);
    return fast ? 3 : 2;
  endfunction

endpackage

// File: rtl/nsc_catch_front.sv
`timescale 1ns/1ps
module nsc_catch_front (
  input  logic strobe_i,
  input  logic rst_i,
  input  logic ack_i,
  output logic level_o
);
  logic kill;
  assign kill = rst_i | ack_i;

  // data input tied high; cleared once the clock domain has seen it
  always_ff @(posedge strobe_i or posedge kill) begin
    if (kill) level_o <= 1'b0;
    else      level_o <= 1'b1;
  end
endmodule

// File: rtl/nsc_toggle_front.sv
`timescale 1ns/1ps
module nsc_toggle_front (
  input  logic strobe_i,
  input  logic rst_i,
  output logic level_o
);
  always_ff @(posedge strobe_i or posedge rst_i) begin
    if (rst_i) level_o <= 1'b0;
    else       level_o <= ~level_o;
  end
endmodule

// File: rtl/nsc_sync_chain.sv
`timescale 1ns/1ps
module nsc_sync_chain #(
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             d_i,
  output logic [DEPTH-1:0] stage_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) stage_o[0] <= 1'b0;
        else       stage_o[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) stage_o[i] <= 1'b0;
        else       stage_o[i] <= stage_o[i-1];
      end
    end
  end
endmodule

// File: rtl/nsc_edge_pulse.sv
`timescale 1ns/1ps
module nsc_edge_pulse
  import nsc_pkg::*;
#(
  parameter cap_mode_e MODE     = CAP_LATCH,
  parameter bit        FAST_CLK = 1'b0
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic level_i,
  output logic hist_o,
  output logic pulse_o
);
  if (MODE == CAP_LATCH && FAST_CLK) begin : g_self_clear
    // third flop clears itself: registered one-cycle pulse, no gate in path
    always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i)       hist_o <= 1'b0;
      else if (hist_o) hist_o <= 1'b0;
      else             hist_o <= level_i;
    end
    assign pulse_o = hist_o;
  end else begin : g_gated
    always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) hist_o <= 1'b0;
      else       hist_o <= level_i;
    end
    if (MODE == CAP_LATCH) begin : g_and
      assign pulse_o = level_i & ~hist_o;
    end else begin : g_xor
      assign pulse_o = level_i ^ hist_o;
    end
  end
endmodule

// File: rtl/strobe_pulse_sync.sv
`timescale 1ns/1ps
module strobe_pulse_sync
  import nsc_pkg::*;
#(
  parameter cap_mode_e MODE     = CAP_LATCH,
  parameter bit        FAST_CLK = 1'b0
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic strobe_i,
  output logic pulse_o
);
  localparam int unsigned DEPTH = sync_depth(MODE, FAST_CLK);

  // named internal events, observed by the bound checker
  logic             front_q;
  logic [DEPTH-1:0] sync_q;
  logic             hist_q;

  if (MODE == CAP_LATCH) begin : g_latch
    logic seen_ack;
    assign seen_ack = sync_q[1];
    nsc_catch_front u_front (
      .strobe_i (strobe_i),
      .rst_i    (rst_i),
      .ack_i    (seen_ack),
      .level_o  (front_q)
    );
  end else begin : g_toggle
    nsc_toggle_front u_front (
      .strobe_i (strobe_i),
      .rst_i    (rst_i),
      .level_o  (front_q)
    );
  end

  nsc_sync_chain #(.DEPTH(DEPTH)) u_sync (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .d_i     (front_q),
    .stage_o (sync_q)
  );

  nsc_edge_pulse #(.MODE(MODE), .FAST_CLK(FAST_CLK)) u_pulse (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .level_i (sync_q[DEPTH-1]),
    .hist_o  (hist_q),
    .pulse_o (pulse_o)
  );
endmodule

// File: rtl/nsc_checker.sv
`timescale 1ns/1ps
module nsc_checker
  import nsc_pkg::*;
#(
  parameter cap_mode_e MODE     = CAP_LATCH,
  parameter bit        FAST_CLK = 1'b0,
  parameter int unsigned DEPTH  = 2
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             pulse_o,
  input logic             front_q,
  input logic [DEPTH-1:0] sync_q
);
  localparam int unsigned LAT = pulse_latency(FAST_CLK);

  logic first_cyc;
  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) first_cyc <= 1'b1;
    else       first_cyc <= 1'b0;
  end

  assert_single_cycle_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    pulse_o |=> !pulse_o);

  assert_quiet_after_reset_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    first_cyc |-> !pulse_o);

  if (MODE == CAP_LATCH) begin : g_latch
    assert_catch_cleared_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      sync_q[1] |-> !front_q);
    assert_latency_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      pulse_o |-> $past(sync_q[0], LAT-1));
  end else begin : g_toggle
    assert_toggle_follow_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      (sync_q[0] != $past(sync_q[0])) |-> ($past(front_q) != $past(sync_q[0])));
    assert_latency_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      pulse_o |-> ($past(sync_q[0], LAT-1) != $past(sync_q[0], LAT)));
  end
endmodule

bind strobe_pulse_sync nsc_checker #(
  .MODE(MODE), .FAST_CLK(FAST_CLK), .DEPTH(DEPTH)
) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .pulse_o (pulse_o),
  .front_q (front_q),
  .sync_q  (sync_q)
);

// File: tb/sim_strobe_pulse_sync.sv
`timescale 1ns/1ps
module sim_strobe_pulse_sync;
  import nsc_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strobe = 1'b0;
  logic [3:0] pls;

  always #5 clk = ~clk;

  strobe_pulse_sync #(.MODE(CAP_LATCH),  .FAST_CLK(1'b0)) u0 (.clk_i(clk), .rst_i(rst), .strobe_i(strobe), .pulse_o(pls[0]));
  strobe_pulse_sync #(.MODE(CAP_LATCH),  .FAST_CLK(1'b1)) u1 (.clk_i(clk), .rst_i(rst), .strobe_i(strobe), .pulse_o(pls[1]));
  strobe_pulse_sync #(.MODE(CAP_TOGGLE), .FAST_CLK(1'b0)) u2 (.clk_i(clk), .rst_i(rst), .strobe_i(strobe), .pulse_o(pls[2]));
  strobe_pulse_sync #(.MODE(CAP_TOGGLE), .FAST_CLK(1'b1)) u3 (.clk_i(clk), .rst_i(rst), .strobe_i(strobe), .pulse_o(pls[3]));

  int cyc = 0;
  int pc[4];
  int plast[4];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    for (int k = 0; k < 4; k++) begin
      if (pls[k]) begin
        pc[k] = pc[k] + 1;
        plast[k] = cyc;
      end
    end
  end

  // expected behaviour restated from the requirements
  function automatic int exp_lat(int k);
    return (k % 2 == 1) ? 3 : 2;
  endfunction

  function automatic bit is_toggle(int k);
    return k >= 2;
  endfunction

  function automatic int exp_double(int k);
    return is_toggle(k) ? 0 : 1;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_strobe(real w);
    strobe = 1'b1;
    #(w);
    strobe = 1'b0;
  endtask

  // one strobe at offset off after a posedge; returns that edge's cycle index
  task automatic fire(real off, real w, output int n);
    @(posedge clk);
    #(off);
    n = cyc;
    pulse_strobe(w);
  endtask

  task automatic single(real off, real w, string req);
    int snap[4];
    int n;
    for (int k = 0; k < 4; k++) snap[k] = pc[k];
    fire(off, w, n);
    repeat (7) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      check(pc[k] - snap[k] == 1, {req, " R3 count"}, pc[k] - snap[k], 1);
      check(plast[k] == n + exp_lat(k), {req, " R4/R6 latency"}, plast[k] - n, exp_lat(k));
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    int snap[4];
    int n;
    void'($urandom(32'h5EED));
    for (int k = 0; k < 4; k++) begin pc[k] = 0; plast[k] = 0; end

    // R8: reset state, strobe during reset ignored
    repeat (2) @(negedge clk);
    check(pls == 4'b0, "R8 reset output", int'(pls), 0);
    fire(2.0, 1.0, n);
    repeat (3) @(negedge clk);
    check(pls == 4'b0, "R8 strobe in reset", int'(pls), 0);
    rst = 1'b0;
    @(negedge clk);
    check(pls == 4'b0, "R8 first cycle after release", int'(pls), 0);
    repeat (5) @(negedge clk);
    for (int k = 0; k < 4; k++) check(pc[k] == 0, "R8 no pulse after release", pc[k], 0);

    // R1: very narrow strobe, R3/R4/R6 basic
    single(2.0, 0.05, "R1 narrow");
    single(2.0, 1.0, "R3 basic");
    single(8.5, 1.2, "R4 late offset");
    single(0.5, 0.3, "R6 early offset");

    // R7: two edges in one clock period
    for (int k = 0; k < 4; k++) snap[k] = pc[k];
    fire(1.0, 1.0, n);
    #2.0;
    pulse_strobe(1.0);
    repeat (7) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      check(pc[k] - snap[k] == exp_double(k), "R7 double strobe", pc[k] - snap[k], exp_double(k));
      if (!is_toggle(k))
        check(plast[k] == n + exp_lat(k), "R7 latch latency", plast[k] - n, exp_lat(k));
    end

    // R5: toggle front flips back after the double; next single still pulses
    single(3.0, 1.0, "R5 toggle after double");

    // R9: strobes 5 periods apart
    for (int k = 0; k < 4; k++) snap[k] = pc[k];
    fire(2.0, 1.0, n);
    repeat (4) @(posedge clk);
    @(posedge clk);
    #2.0;
    pulse_strobe(1.0);
    repeat (8) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      check(pc[k] - snap[k] == 2, "R9 spaced pair count", pc[k] - snap[k], 2);
      check(plast[k] == n + 5 + exp_lat(k), "R9 second latency", plast[k] - n, 5 + exp_lat(k));
    end

    // R8: reset while an event is in flight
    for (int k = 0; k < 4; k++) snap[k] = pc[k];
    fire(2.0, 1.0, n);
    @(posedge clk);
    #1.0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (7) @(negedge clk);
    for (int k = 0; k < 4; k++)
      check(pc[k] == snap[k], "R8 in-flight event dropped", pc[k] - snap[k], 0);

    // random offsets, widths and gaps (R3, R4, R9)
    for (int it = 0; it < 40; it++) begin
      real off;
      real w;
      off = 1.0 + real'($urandom % 600) / 100.0;
      w   = 0.1 + real'($urandom % 100) / 100.0;
      repeat ($urandom % 4) @(posedge clk);
      single(off, w, "R3 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule